// File: doc/BRIEF.md
# Bank Address Mapper with Direct Resource Decode

The mapper sits between a CPU with a 16-bit address and a set of memory and I/O resources. Each resource has its own 19-bit word address space. The top four CPU address bits pick one of sixteen map entries, and each entry is 12 bits wide. The upper five bits of the selected entry drive an active-low resource select bus directly: a resource is chosen by clearing its bit and leaving the other bits at 1. The lower seven bits of the entry become the high part of the resource address, and CPU address bits 11:0 supply the rest. An entry of all ones selects the console switch bank instead of a resource.

After reset, mapping is off. A two-bit boot select input then picks ROM, RAM or expansion I/O, and the CPU address passes through with zero padding. If the boot select names no device, the console switches supply the boot word. Software loads the entries and the enable bit through a small register port. Every write through that port stretches the bus cycle by one wait state, so that the register strobe stays high for one full clock.

Top module: `bank_mapper`

## Requirements
- R1: After reset, mapping is disabled, `bus_wait` and `map_strobe` are low, and reads of every map entry and of the control register return 0.
- R2: While mapping is disabled, `res_sel_n` is decoded from `boot_sel`: code 0 (ROM) clears bit 0, code 1 (RAM) clears bit 1 and code 2 (I/O) clears bit 2, with all other bits at 1. Code 3 (none) drives all select bits to 1 and raises `console_sel`. `res_addr` is the CPU address with three leading zeros.
- R3: While mapping is enabled, the entry indexed by `cpu_addr[15:12]` drives `res_sel_n` from its bits 11:7, and `res_addr` is entry bits 6:0 followed by `cpu_addr[11:0]`.
- R4: While mapping is enabled, an entry equal to 12'hFFF raises `console_sel`, and `res_sel_n` is then all ones. Any other entry keeps `console_sel` low.
- R5: A write request (`reg_wr` high) made while the port is idle raises `bus_wait` combinationally in that cycle. In the next cycle `map_strobe` is high and `bus_wait` is low. The data and address captured in the request cycle take effect at the end of the strobe cycle, and changes to `reg_wdata` during the strobe cycle are ignored.
- R6: On the register port, `reg_addr[4]`=0 selects map entry `reg_addr[3:0]`. `reg_addr[4]`=1 selects the control register, whose bit 0 is the mapping enable. A read returns the stored 12 bits of the entry, or the enable bit in bit 0 of the control register with zeros above it.
- R7: While mapping is enabled, `boot_sel` has no effect on `res_sel_n`, `res_addr` or `console_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | CPU word address |
| boot_sel | input | 2 | Boot resource select used while mapping is off |
| reg_wr | input | 1 | Register port write request |
| reg_addr | input | 5 | Register port address: bit 4 selects control, bits 3:0 select the entry |
| reg_wdata | input | 12 | Register port write data |
| reg_rdata | output | 12 | Register port read data |
| res_addr | output | 19 | Resource word address |
| res_sel_n | output | 5 | Active-low direct resource selects |
| console_sel | output | 1 | Console switch bank selected |
| bus_wait | output | 1 | Wait request to the CPU during a register write |
| map_strobe | output | 1 | Full-cycle register write strobe |

## Verification
The bench changes `reg_wdata` in the middle of each write. A mapper that captured data at the strobe edge instead of at the request would store the altered value, and the read-back would catch it. The 12'hFFF entry is loaded next to entries that differ from it in only one bit. A design that tested only the select field for the console case would raise `console_sel` for those near-miss entries. In both boot and mapped modes the bench sweeps random addresses with random boot codes, so a design that let `boot_sel` leak into mapped mode, or that took the page bits from the wrong field, would drive a wrong select or address. Turning mapping off again at the end checks that the design falls back to boot decode and does not keep the last entry.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;
   typedef enum logic [1:0] {
      BOOT_ROM  = 2'd0,
      BOOT_RAM  = 2'd1,
      BOOT_IO   = 2'd2,
      BOOT_NONE = 2'd3
   } boot_sel_e;

   typedef enum logic {
      WR_IDLE   = 1'b0,
      WR_STROBE = 1'b1
   } wr_state_e;
endpackage

// File: rtl/bank_wr_seq.sv
module bank_wr_seq
   import bank_mapper_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic capture,
   output logic commit,
   output logic wait_o,
   output logic strobe_o
);
   wr_state_e state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WR_IDLE;
      end else begin
         case (state_q)
            WR_IDLE:   if (req) state_q <= WR_STROBE;
            WR_STROBE: state_q <= WR_IDLE;
            default:   state_q <= WR_IDLE;
         endcase
      end
   end

   always_comb begin
      capture  = req && (state_q == WR_IDLE);
      commit   = (state_q == WR_STROBE);
      wait_o   = capture;
      strobe_o = commit;
   end

   // R5
   wait_then_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wait_o |=> (strobe_o && !wait_o));

   // R5
   strobe_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_o |=> !strobe_o);

   // R5
   strobe_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strobe_o) |-> $past(wait_o));
endmodule

// File: rtl/bank_map_regs.sv
module bank_map_regs #(
   parameter int BANKS = 16,
   parameter int MAP_W = 12,
   localparam int IDX_W = $clog2(BANKS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             commit,
   input  logic             wr_ctrl,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [MAP_W-1:0] wr_data,
   input  logic [IDX_W-1:0] lk_idx,
   output logic [MAP_W-1:0] lk_entry,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [MAP_W-1:0] rd_entry,
   output logic             map_en
);
   logic [MAP_W-1:0] entries [BANKS];

   initial begin
      assert (BANKS == (1 << IDX_W)) else $error("BANKS must be a power of two");
      assert (MAP_W > 1) else $error("MAP_W too small");
   end

   for (genvar i = 0; i < BANKS; i++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            entries[i] <= '0;
         else if (commit && !wr_ctrl && (wr_idx == IDX_W'(i)))
            entries[i] <= wr_data;
      end

      // R5
      entry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !commit |=> $stable(entries[i]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         map_en <= 1'b0;
      else if (commit && wr_ctrl)
         map_en <= wr_data[0];
   end

   assign lk_entry = entries[lk_idx];
   assign rd_entry = entries[rd_idx];

   // R6
   enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(map_en));
endmodule

// File: rtl/bank_decode.sv
module bank_decode
   import bank_mapper_pkg::*;
#(
   parameter int CPU_AW    = 16,
   parameter int BANK_BITS = 4,
   parameter int MAP_W     = 12,
   parameter int SEL_W     = 5,
   localparam int OFF_W    = CPU_AW - BANK_BITS,
   localparam int PAGE_W   = MAP_W - SEL_W,
   localparam int RES_AW   = PAGE_W + OFF_W
) (
   input  logic              map_en,
   input  logic [MAP_W-1:0]  entry,
   input  logic [CPU_AW-1:0] cpu_addr,
   input  logic [1:0]        boot_sel,
   output logic [RES_AW-1:0] res_addr,
   output logic [SEL_W-1:0]  res_sel_n,
   output logic              console_sel
);
   logic [SEL_W-1:0] boot_n;

   initial begin
      assert (SEL_W >= 3) else $error("SEL_W must cover ROM, RAM and I/O");
      assert (MAP_W > SEL_W) else $error("MAP_W must exceed SEL_W");
      assert (RES_AW > CPU_AW) else $error("resource space must exceed CPU space");
   end

   for (genvar r = 0; r < SEL_W; r++) begin : g_boot
      if (r < 3) begin : g_dev
         assign boot_n[r] = (boot_sel != 2'(r));
      end else begin : g_idle
         assign boot_n[r] = 1'b1;
      end
   end

   always_comb begin
      if (map_en) begin
         console_sel = &entry;
         res_sel_n   = console_sel ? '1 : entry[MAP_W-1 -: SEL_W];
         res_addr    = {entry[PAGE_W-1:0], cpu_addr[OFF_W-1:0]};
      end else begin
         console_sel = (boot_sel == BOOT_NONE);
         res_sel_n   = boot_n;
         res_addr    = RES_AW'(cpu_addr);
      end
   end
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper #(
   parameter int CPU_AW    = 16,
   parameter int BANK_BITS = 4,
   parameter int MAP_W     = 12,
   parameter int SEL_W     = 5,
   localparam int BANKS    = 1 << BANK_BITS,
   localparam int OFF_W    = CPU_AW - BANK_BITS,
   localparam int RES_AW   = MAP_W - SEL_W + OFF_W,
   localparam int RA_W     = BANK_BITS + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CPU_AW-1:0] cpu_addr,
   input  logic [1:0]        boot_sel,
   input  logic              reg_wr,
   input  logic [RA_W-1:0]   reg_addr,
   input  logic [MAP_W-1:0]  reg_wdata,
   output logic [MAP_W-1:0]  reg_rdata,
   output logic [RES_AW-1:0] res_addr,
   output logic [SEL_W-1:0]  res_sel_n,
   output logic              console_sel,
   output logic              bus_wait,
   output logic              map_strobe
);
   logic                 capture, commit, map_en;
   logic [RA_W-1:0]      wr_addr_q;
   logic [MAP_W-1:0]     wr_data_q;
   logic [MAP_W-1:0]     lk_entry, rd_entry;

   initial begin
      assert (BANK_BITS > 0 && BANK_BITS < CPU_AW) else $error("bad BANK_BITS");
   end

   bank_wr_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (reg_wr),
      .capture  (capture),
      .commit   (commit),
      .wait_o   (bus_wait),
      .strobe_o (map_strobe)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_addr_q <= '0;
         wr_data_q <= '0;
      end else if (capture) begin
         wr_addr_q <= reg_addr;
         wr_data_q <= reg_wdata;
      end
   end

   bank_map_regs #(.BANKS(BANKS), .MAP_W(MAP_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .commit   (commit),
      .wr_ctrl  (wr_addr_q[BANK_BITS]),
      .wr_idx   (wr_addr_q[BANK_BITS-1:0]),
      .wr_data  (wr_data_q),
      .lk_idx   (cpu_addr[CPU_AW-1 -: BANK_BITS]),
      .lk_entry (lk_entry),
      .rd_idx   (reg_addr[BANK_BITS-1:0]),
      .rd_entry (rd_entry),
      .map_en   (map_en)
   );

   assign reg_rdata = reg_addr[BANK_BITS] ? MAP_W'(map_en) : rd_entry;

   bank_decode #(
      .CPU_AW(CPU_AW), .BANK_BITS(BANK_BITS), .MAP_W(MAP_W), .SEL_W(SEL_W)
   ) u_dec (
      .map_en      (map_en),
      .entry       (lk_entry),
      .cpu_addr    (cpu_addr),
      .boot_sel    (boot_sel),
      .res_addr    (res_addr),
      .res_sel_n   (res_sel_n),
      .console_sel (console_sel)
   );

   // R2
   boot_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !map_en |-> $onehot0(~res_sel_n));

   // R2
   boot_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !map_en |-> (res_addr[RES_AW-1:CPU_AW] == '0));

   // R3
   offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      map_en |-> (res_addr[OFF_W-1:0] == cpu_addr[OFF_W-1:0]));

   // R4
   console_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      console_sel |-> (&res_sel_n));
endmodule

// File: tb/tb_bank_mapper.sv
module tb_bank_mapper;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [1:0]  boot_sel = '0;
   logic        reg_wr = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [11:0] reg_wdata = '0;
   logic [11:0] reg_rdata;
   logic [18:0] res_addr;
   logic [4:0]  res_sel_n;
   logic        console_sel, bus_wait, map_strobe;

   int checks = 0;
   int errors = 0;
   logic [11:0] model [16];
   logic        model_en = 1'b0;

   bank_mapper dut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .boot_sel(boot_sel),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .res_addr(res_addr), .res_sel_n(res_sel_n),
      .console_sel(console_sel), .bus_wait(bus_wait), .map_strobe(map_strobe)
   );

   always #10 clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [4:0] exp_sel(input logic [15:0] a, input logic [1:0] b);
      logic [11:0] e;
      if (!model_en) begin
         if (b == 2'd3) return 5'b11111;
         return ~(5'b00001 << b);
      end
      e = model[a[15:12]];
      if (e == 12'hFFF) return 5'b11111;
      return e[11:7];
   endfunction

   function automatic logic [18:0] exp_addr(input logic [15:0] a);
      if (!model_en) return {3'b000, a};
      return {model[a[15:12]][6:0], a[11:0]};
   endfunction

   function automatic logic exp_con(input logic [15:0] a, input logic [1:0] b);
      if (!model_en) return (b == 2'd3);
      return (model[a[15:12]] == 12'hFFF);
   endfunction

   task automatic do_write(input logic [4:0] a, input logic [11:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      #1;
      chk("R5 wait in request cycle", bus_wait, 1'b1);
      chk("R5 no strobe in request cycle", map_strobe, 1'b0);
      @(negedge clk);
      chk("R5 strobe cycle", {map_strobe, bus_wait}, 2'b10);
      reg_wdata = ~d;
      reg_wr = 1'b0;
      @(negedge clk);
      if (a[4]) model_en = d[0];
      else model[a[3:0]] = d;
   endtask

   task automatic do_read(input logic [4:0] a, input logic [11:0] exp, input string req);
      @(negedge clk);
      reg_addr = a;
      #1;
      chk(req, reg_rdata, exp);
   endtask

   task automatic probe(input logic [15:0] a, input logic [1:0] b, input string req);
      @(negedge clk);
      cpu_addr = a; boot_sel = b;
      #1;
      chk({req, " sel"}, res_sel_n, exp_sel(a, b));
      chk({req, " addr"}, res_addr, exp_addr(a));
      chk({req, " console"}, console_sel, exp_con(a, b));
   endtask

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed1234));
      for (int i = 0; i < 16; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 wait low", bus_wait, 1'b0);
      chk("R1 strobe low", map_strobe, 1'b0);
      do_read(5'h10, 12'h000, "R1 control reads 0");
      do_read(5'h05, 12'h000, "R1 entry reads 0");
      do_read(5'h0F, 12'h000, "R1 last entry reads 0");
      probe(16'h0000, 2'd0, "R1 boot ROM");

      // R2 boot decode for every code
      for (int b = 0; b < 4; b++) probe(16'($urandom), 2'(b), "R2 boot");
      for (int i = 0; i < 40; i++) probe(16'($urandom), 2'($urandom), "R2 boot rand");

      // R5/R6 load entries, with directed corner entries
      for (int i = 0; i < 16; i++) begin
         logic [11:0] v = 12'($urandom);
         if (i == 3) v = 12'hFFF;
         if (i == 4) v = 12'hFFE;
         if (i == 5) v = 12'h7FF;
         if (i == 6) v = 12'hF80;
         if (i == 7) v = 12'b11110_0000001;
         if (v == 12'hFFF && i != 3) v = 12'hABC;
         do_write(5'(i), v);
      end
      for (int i = 0; i < 16; i++) do_read(5'(i), model[i], "R6 read back entry");
      probe(16'h5123, 2'd1, "R6 writes do not enable mapping");

      do_write(5'h10, 12'h001);
      do_read(5'h10, 12'h001, "R6 control enable bit");

      // R4 console entry and near misses
      probe(16'h3ABC, 2'd0, "R4 console bank");
      probe(16'h4ABC, 2'd0, "R4 near miss low bit");
      probe(16'h5ABC, 2'd0, "R4 near miss top bit");
      probe(16'h6001, 2'd3, "R3 top field all ones page 0");
      probe(16'h7FFF, 2'd2, "R3 ROM select page 1");

      // R3 and R7 mapped lookups with random boot codes
      for (int i = 0; i < 150; i++) probe(16'($urandom), 2'($urandom), "R3 R7 mapped");

      // R5 interleaved rewrites
      for (int i = 0; i < 30; i++) begin
         logic [3:0] k = 4'($urandom);
         do_write({1'b0, k}, 12'($urandom));
         do_read({1'b0, k}, model[k], "R5 rewrite committed");
         probe({k, 12'($urandom)}, 2'($urandom), "R3 after rewrite");
      end

      // R2 back to boot decode
      do_write(5'h10, 12'h000);
      do_read(5'h10, 12'h000, "R6 control cleared");
      for (int b = 0; b < 4; b++) probe(16'($urandom), 2'(b), "R2 boot after disable");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule